// File: doc/BRIEF.md
# Timer Trigger Output and Request Routing Unit

This block is the configuration slice of a general-purpose timer that decides three things: which signal the timer feeds into its first timer input, what the timer presents on its trigger output to slave timers, and when the capture/compare DMA requests fire. It contains one 16-bit configuration word on a simple register bus. All other timer logic lives outside the block: the counter, the compare channels and the slave-mode controller. That logic supplies the event strobes and the reference levels that this block selects from.

The trigger output comes from an eight-way selector. Some of its sources are levels, such as the counter enable and the four compare reference outputs. Others are single-cycle pulses, such as the software update request, the update event and the channel-1 flag-set strobe. The first timer input can be a single channel pin, or the XOR of three channel pins for rotary position sensing. Every output is registered. A configuration change therefore acts on the clock after the write and cannot glitch the outputs.

Top module: `tmr_trig_ctl`

## Requirements
- R1: The configuration word sits at bus offset 0x04 and resets to 0x0000. A read strobe returns the word on `bus_rdata` one clock later. A read at any other offset returns 0x0000.
- R2: Bits 15:8 and 2:0 always read as zero, and writing to them has no effect. A write at any offset other than 0x04 leaves the word unchanged.
- R3: Bit 7 selects the first timer input. When it is 0, `ti1` follows `ch_pin[0]`. When it is 1, `ti1` is the XOR of `ch_pin[2:0]`. In both cases the output appears one clock after the pins are sampled.
- R4: Bits 6:4 select the trigger source with this encoding: 0 software update request, 1 counter enable, 2 update event, 3 channel-1 flag-set pulse, 4 to 7 compare references 1 to 4. `trgo` is registered and lags its source by one clock.
- R5: The counter enable used as source 1 is `cen_bit OR (slave_gated AND trig_in)`.
- R6: For each pulse source (0, 2 and 3), every input pulse gives exactly one clock of `trgo` high. Back-to-back channel-1 flag-set strobes give one high clock each, with no merging, even when the flag is already set.
- R7: Sources 4, 5, 6 and 7 drive `trgo` with the levels of `oc_ref[0]`, `oc_ref[1]`, `oc_ref[2]` and `oc_ref[3]`.
- R8: When bit 3 is 0, `dma_req[i]` pulses one clock after `cc_evt[i]` and `dma_en[i]` are both high. In this mode `upd_evt` has no effect on the requests.
- R9: When bit 3 is 1, an update event pulses `dma_req[i]` one clock later for every channel whose `dma_en[i]` is set. In this mode `cc_evt` has no effect on the requests.
- R10: A write that changes the source selection takes effect on the following clock. An event in the same cycle as the write is routed by the old selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ch_pin | input | 3 | Channel 1 to 3 input pins |
| sw_upd_gen | input | 1 | Software update request pulse |
| cen_bit | input | 1 | Counter enable control bit |
| slave_gated | input | 1 | Slave controller is in gated mode |
| trig_in | input | 1 | Slave trigger input |
| upd_evt | input | 1 | Update event pulse |
| cc1_set | input | 1 | Channel-1 flag-set strobe |
| oc_ref | input | 4 | Compare reference levels, channels 1 to 4 |
| cc_evt | input | 4 | Per-channel capture/compare event pulses |
| dma_en | input | 4 | Per-channel DMA request enables |
| ti1 | output | 1 | Selected first timer input |
| trgo | output | 1 | Trigger output to slave timers |
| dma_req | output | 4 | Per-channel DMA request strobes |

## Verification
A configuration write and a selected event can arrive in the same clock. The case of interest is a source-field write from counter-enable to update-event while `upd_evt` pulses, along with the reverse switch. The bench provokes both collisions. It expects `trgo` to follow the old source in the write cycle and the new source from the next event onward. The expected values come from an in-order queue of predictions that is filled cycle by cycle as the stimulus is applied.

// File: rtl/tmr_trig_pkg.sv
`timescale 1ns/1ps
package tmr_trig_pkg;
  localparam int CFG_W      = 16;
  localparam int POS_XOR    = 7;
  localparam int POS_SRC_LO = 4;
  localparam int SRC_W      = 3;
  localparam int POS_DMAUPD = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_UG   = 3'd0,
    SRC_CEN  = 3'd1,
    SRC_UPD  = 3'd2,
    SRC_CC1P = 3'd3,
    SRC_OC1  = 3'd4,
    SRC_OC2  = 3'd5,
    SRC_OC3  = 3'd6,
    SRC_OC4  = 3'd7
  } trig_src_e;

  typedef struct packed {
    logic      xor_in;
    trig_src_e src;
    logic      dma_on_upd;
  } trig_cfg_t;
endpackage

// File: rtl/tmr_trig_regs.sv
`timescale 1ns/1ps
module tmr_trig_regs
  import tmr_trig_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] OFFSET = 'h04
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output trig_cfg_t         cfg
);
  localparam int SRC_HI = POS_SRC_LO + SRC_W - 1;

  logic              hit;
  logic [DATA_W-1:0] word;
  logic              unused_wbits;

  assign hit = (addr == OFFSET);
  assign unused_wbits = ^{wdata[DATA_W-1:POS_XOR+1], wdata[POS_DMAUPD-1:0]};

  always_comb begin
    word = '0;
    word[POS_XOR]             = cfg.xor_in;
    word[SRC_HI:POS_SRC_LO]   = cfg.src;
    word[POS_DMAUPD]          = cfg.dma_on_upd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '{xor_in: 1'b0, src: SRC_UG, dma_on_upd: 1'b0};
    end else if (wr && hit) begin
      cfg.xor_in     <= wdata[POS_XOR];
      cfg.src        <= trig_src_e'(wdata[SRC_HI:POS_SRC_LO]);
      cfg.dma_on_upd <= wdata[POS_DMAUPD];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= hit ? word : '0;
  end

  // R2
  wr_field_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && hit) |=> (cfg.src == $past(wdata[SRC_HI:POS_SRC_LO]) &&
                     cfg.xor_in == $past(wdata[POS_XOR])));
  // R2
  wr_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && !hit) |=> $stable(cfg));
endmodule

// File: rtl/tmr_trig_ti1.sv
`timescale 1ns/1ps
module tmr_trig_ti1 #(
  parameter int N_PIN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xor_in,
  input  logic [N_PIN-1:0] pin,
  output logic             ti1
);
  logic sel;

  assign sel = xor_in ? (^pin) : pin[0];

  always_ff @(posedge clk) begin
    if (rst) ti1 <= 1'b0;
    else     ti1 <= sel;
  end

  // R3
  ti1_direct_chk: assert property (@(posedge clk) disable iff (rst)
    !xor_in |=> (ti1 == $past(pin[0])));
endmodule

// File: rtl/tmr_trig_mux.sv
`timescale 1ns/1ps
module tmr_trig_mux
  import tmr_trig_pkg::*;
#(
  parameter int N_OC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  trig_src_e       src,
  input  logic            sw_upd_gen,
  input  logic            cen_bit,
  input  logic            slave_gated,
  input  logic            trig_in,
  input  logic            upd_evt,
  input  logic            cc1_set,
  input  logic [N_OC-1:0] oc_ref,
  output logic            trgo
);
  logic cnt_en;
  logic nxt;

  assign cnt_en = cen_bit | (slave_gated & trig_in);

  always_comb begin
    unique case (src)
      SRC_UG:   nxt = sw_upd_gen;
      SRC_CEN:  nxt = cnt_en;
      SRC_UPD:  nxt = upd_evt;
      SRC_CC1P: nxt = cc1_set;
      SRC_OC1:  nxt = oc_ref[0];
      SRC_OC2:  nxt = oc_ref[1];
      SRC_OC3:  nxt = oc_ref[2];
      SRC_OC4:  nxt = oc_ref[3];
      default:  nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) trgo <= 1'b0;
    else     trgo <= nxt;
  end

  // R6
  upd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_UPD && upd_evt) |=> trgo);
  // R6
  cc1_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_CC1P && !cc1_set) |=> !trgo);
  // R5
  cen_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_CEN && slave_gated && trig_in) |=> trgo);
endmodule

// File: rtl/tmr_trig_dma.sv
`timescale 1ns/1ps
module tmr_trig_dma #(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dma_on_upd,
  input  logic            upd_evt,
  input  logic [N_CH-1:0] cc_evt,
  input  logic [N_CH-1:0] dma_en,
  output logic [N_CH-1:0] dma_req
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic fire;
    assign fire = dma_en[i] & (dma_on_upd ? upd_evt : cc_evt[i]);
    always_ff @(posedge clk) begin
      if (rst) dma_req[i] <= 1'b0;
      else     dma_req[i] <= fire;
    end
  end

  // R9
  dma_upd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_on_upd && !upd_evt) |=> (dma_req == '0));
  // R8
  dma_evt_chk: assert property (@(posedge clk) disable iff (rst)
    !dma_on_upd |=> (dma_req == $past(cc_evt & dma_en)));
endmodule

// File: rtl/tmr_trig_ctl.sv
`timescale 1ns/1ps
module tmr_trig_ctl
  import tmr_trig_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h04,
  parameter int N_PIN = 3,
  parameter int N_CH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_PIN-1:0]  ch_pin,
  input  logic              sw_upd_gen,
  input  logic              cen_bit,
  input  logic              slave_gated,
  input  logic              trig_in,
  input  logic              upd_evt,
  input  logic              cc1_set,
  input  logic [N_CH-1:0]   oc_ref,
  input  logic [N_CH-1:0]   cc_evt,
  input  logic [N_CH-1:0]   dma_en,
  output logic              ti1,
  output logic              trgo,
  output logic [N_CH-1:0]   dma_req
);
  trig_cfg_t cfg;

  tmr_trig_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFSET(REG_OFFSET)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .rdata(bus_rdata), .cfg(cfg)
  );

  tmr_trig_ti1 #(.N_PIN(N_PIN)) u_ti1 (
    .clk(clk), .rst(rst), .xor_in(cfg.xor_in), .pin(ch_pin), .ti1(ti1)
  );

  tmr_trig_mux #(.N_OC(N_CH)) u_mux (
    .clk(clk), .rst(rst), .src(cfg.src), .sw_upd_gen(sw_upd_gen),
    .cen_bit(cen_bit), .slave_gated(slave_gated), .trig_in(trig_in),
    .upd_evt(upd_evt), .cc1_set(cc1_set), .oc_ref(oc_ref), .trgo(trgo)
  );

  tmr_trig_dma #(.N_CH(N_CH)) u_dma (
    .clk(clk), .rst(rst), .dma_on_upd(cfg.dma_on_upd), .upd_evt(upd_evt),
    .cc_evt(cc_evt), .dma_en(dma_en), .dma_req(dma_req)
  );

  // R10
  src_switch_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == REG_OFFSET && cfg.src == SRC_CEN && !cen_bit && !slave_gated)
      |=> !trgo);
endmodule

// File: tb/tmr_trig_ctl_bench.sv
`timescale 1ns/1ps
module tmr_trig_ctl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  ch_pin = '0;
  logic        sw_upd_gen = 0, cen_bit = 0, slave_gated = 0, trig_in = 0;
  logic        upd_evt = 0, cc1_set = 0;
  logic [3:0]  oc_ref = '0, cc_evt = '0, dma_en = '0;
  logic        ti1, trgo;
  logic [3:0]  dma_req;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct {
    bit m_t; bit t;
    bit m_i; bit i;
    bit m_d; logic [3:0] d;
    bit m_r; logic [15:0] r;
    string tag;
  } exp_t;
  exp_t q[$];

  tmr_trig_ctl u_tmr_trig_ctl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_pin(ch_pin),
    .sw_upd_gen(sw_upd_gen), .cen_bit(cen_bit), .slave_gated(slave_gated),
    .trig_in(trig_in), .upd_evt(upd_evt), .cc1_set(cc1_set), .oc_ref(oc_ref),
    .cc_evt(cc_evt), .dma_en(dma_en), .ti1(ti1), .trgo(trgo), .dma_req(dma_req)
  );

  always #4 clk = ~clk;

  task automatic cmp(input logic [15:0] act, input logic [15:0] expv,
                     input string tag, input string what);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // monitor: one prediction per cycle, judged just after the edge
  always begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (e.m_t) cmp({15'd0, trgo}, {15'd0, e.t}, e.tag, "trgo");
      if (e.m_i) cmp({15'd0, ti1}, {15'd0, e.i}, e.tag, "ti1");
      if (e.m_d) cmp({12'd0, dma_req}, {12'd0, e.d}, e.tag, "dma_req");
      if (e.m_r) cmp(bus_rdata, e.r, e.tag, "rdata");
    end
  end

  function automatic exp_t blank(input string tag);
    exp_t e;
    e.m_t = 0; e.t = 0; e.m_i = 0; e.i = 0; e.m_d = 0; e.d = '0;
    e.m_r = 0; e.r = '0; e.tag = tag;
    return e;
  endfunction

  task automatic go();
    @(negedge clk);
  endtask

  task automatic push_go(input exp_t e);
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic exp_trgo(input bit v, input string tag);
    exp_t e = blank(tag);
    e.m_t = 1; e.t = v;
    push_go(e);
  endtask

  task automatic exp_ti1(input bit v, input string tag);
    exp_t e = blank(tag);
    e.m_i = 1; e.i = v;
    push_go(e);
  endtask

  task automatic exp_dma(input logic [3:0] v, input string tag);
    exp_t e = blank(tag);
    e.m_d = 1; e.d = v;
    push_go(e);
  endtask

  // writes junk into the reserved bits on purpose
  function automatic logic [15:0] cfgw(input bit x, input logic [2:0] m, input bit c);
    return {8'hA5, x, m, c, 3'b101};
  endfunction

  function automatic logic [15:0] cfgr(input bit x, input logic [2:0] m, input bit c);
    return {8'h00, x, m, c, 3'b000};
  endfunction

  task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    go();
    bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [15:0] v, input string tag);
    exp_t e = blank(tag);
    bus_addr = a; bus_rd = 1;
    e.m_r = 1; e.r = v;
    push_go(e);
    bus_rd = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) go();
    rst = 0;
    // R1 reset state
    begin
      exp_t e = blank("R1 reset");
      e.m_t = 1; e.m_i = 1; e.m_d = 1;
      push_go(e);
    end
    rd_chk(8'h04, 16'h0000, "R1 reset value");

    // R2 reserved bits dropped, foreign offset ignored
    wr_reg(8'h04, 16'hFFFF);
    rd_chk(8'h04, 16'h00F8, "R2 reserved bits");
    wr_reg(8'h08, 16'h0000);
    rd_chk(8'h04, 16'h00F8, "R2 foreign offset write");
    rd_chk(8'h0C, 16'h0000, "R1 foreign offset read");

    // R3 direct pin
    wr_reg(8'h04, cfgw(0, 3'd0, 0));
    rd_chk(8'h04, cfgr(0, 3'd0, 0), "R1 readback");
    ch_pin = 3'b110; exp_ti1(0, "R3 direct");
    ch_pin = 3'b001; exp_ti1(1, "R3 direct");
    // R3 xor of three pins
    wr_reg(8'h04, cfgw(1, 3'd0, 0));
    ch_pin = 3'b011; exp_ti1(0, "R3 xor");
    ch_pin = 3'b111; exp_ti1(1, "R3 xor");
    ch_pin = 3'b100; exp_ti1(1, "R3 xor");
    ch_pin = 3'b000;

    // R4/R6 source 0: software update request
    wr_reg(8'h04, cfgw(0, 3'd0, 0));
    sw_upd_gen = 1; exp_trgo(1, "R6 ug pulse");
    sw_upd_gen = 0; exp_trgo(0, "R6 ug pulse end");

    // R5 source 1: counter enable
    wr_reg(8'h04, cfgw(0, 3'd1, 0));
    cen_bit = 1; exp_trgo(1, "R5 cen bit");
    cen_bit = 0; slave_gated = 1; trig_in = 1; exp_trgo(1, "R5 gated trigger");
    slave_gated = 0; exp_trgo(0, "R5 trigger not gated");
    trig_in = 0;

    // R6 source 2: update event
    wr_reg(8'h04, cfgw(0, 3'd2, 0));
    upd_evt = 1; exp_trgo(1, "R6 update");
    upd_evt = 0; exp_trgo(0, "R6 update end");

    // R6 source 3: flag-set pulses, back to back then separated
    wr_reg(8'h04, cfgw(0, 3'd3, 0));
    cc1_set = 1; exp_trgo(1, "R6 cc1 first");
    cc1_set = 1; exp_trgo(1, "R6 cc1 repeat");
    cc1_set = 0; exp_trgo(0, "R6 cc1 gap");
    cc1_set = 1; exp_trgo(1, "R6 cc1 again");
    cc1_set = 0; exp_trgo(0, "R6 cc1 end");

    // R7 compare references, only channel 3 high
    oc_ref = 4'b0100;
    for (int m = 4; m < 8; m++) begin
      wr_reg(8'h04, cfgw(0, m[2:0], 0));
      exp_trgo(m == 6, "R7 oc level");
    end
    oc_ref = 4'b0000;
    exp_trgo(0, "R7 oc level low");

    // R8 per-channel events
    wr_reg(8'h04, cfgw(0, 3'd0, 0));
    dma_en = 4'b1011;
    cc_evt = 4'b1110; exp_dma(4'b1010, "R8 channel events");
    cc_evt = 4'b0000; upd_evt = 1; exp_dma(4'b0000, "R8 update ignored");
    upd_evt = 0;

    // R9 requests on update
    wr_reg(8'h04, cfgw(0, 3'd0, 1));
    dma_en = 4'b0111; upd_evt = 1; exp_dma(4'b0111, "R9 update strobe");
    upd_evt = 0; cc_evt = 4'b1111; exp_dma(4'b0000, "R9 channel events ignored");
    cc_evt = 4'b0000; dma_en = 4'b0000;

    // R10 collision: switch counter-enable -> update while update pulses
    wr_reg(8'h04, cfgw(0, 3'd1, 0));
    cen_bit = 0;
    bus_addr = 8'h04; bus_wdata = cfgw(0, 3'd2, 0); bus_wr = 1; upd_evt = 1;
    exp_trgo(0, "R10 old source in write cycle");
    bus_wr = 0; upd_evt = 1; exp_trgo(1, "R10 new source");
    upd_evt = 0; exp_trgo(0, "R10 new source idle");
    // reverse: update -> software request while update pulses
    bus_wdata = cfgw(0, 3'd0, 0); bus_wr = 1; upd_evt = 1;
    exp_trgo(1, "R10 old update source");
    bus_wr = 0; upd_evt = 1; exp_trgo(0, "R10 update no longer routed");
    upd_evt = 0;

    repeat (2) go();
    finish_run();
  end
endmodule